// File: doc/BRIEF.md
# Three-Row Sliding Window Buffer for a Modulo-PCM Decoder

This block sits in front of the sample decoder of a modulo-PCM image decoder. Codewords arrive one per accepted beat in raster order. They are stored in three row stores. The block then presents, one group at a time, the 3x3 neighbourhood of codewords that the decoder needs to rebuild one 2x2 pixel group. Every group's top-left codeword sits at an even row and an even column. That codeword is the plainly quantised sample, and the neighbours to its right and below belong to the next group. For this reason the window moves two columns per group and two rows per strip, and the last column and row are kept as overlap.

The frame size is given at run time on two inputs. Both dimensions must be even, at least 2, and no larger than the build maxima. Where the right or bottom neighbour lies outside the frame, the last column or row is repeated. Both edges of the block use a valid/ready handshake. The input is stalled whenever accepting another codeword would overwrite a row that the current strip still reads.

Top module: `sldwin_top`

## Requirements
- R1: For the group in strip s and column pair g, window slot k of row r (r,k in 0..2) holds the codeword at frame row 2s+r and column 2g+k. The slot is at bits [(3r+k)*CW +: CW] of `win_data`.
- R2: Groups come out left to right, W/2 per strip, and strips come out top to bottom, H/2 per frame. Each group is presented exactly once, and no window follows the last group until new data arrives.
- R3: In the last group of a strip, the third column of the window repeats column W-1.
- R4: In the last strip, the third row of the window repeats row H-1.
- R5: No window is offered for a strip until its rows 2s, 2s+1 and 2s+2 have been fully received. For the last strip, the requirement is every row of the frame.
- R6: While strip s is open, `in_ready` is low for any codeword of row 2s+3 or later. Once all H rows have been taken, `in_ready` stays low until the last window of the frame is accepted. With the output stalled from the start, exactly 3W codewords are accepted.
- R7: While `out_valid` is high and `out_ready` is low, the window, markers and parities stay unchanged and `out_valid` stays high.
- R8: `win_sof` is high only with the first group of a frame. `win_eof` is high only with its last group.
- R9: `win_row_odd` equals s mod 2 and `win_col_odd` equals g mod 2 for the presented group.
- R10: Accepting the end-of-frame window empties the buffer. The next frame's codewords are accepted at once, and its first window carries `win_sof`.
- R11: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_w | input | $clog2(MAX_W+1) | Frame width in codewords, even, held during a frame |
| frame_h | input | $clog2(MAX_H+1) | Frame height in rows, even, held during a frame |
| in_valid | input | 1 | Input codeword valid |
| in_ready | output | 1 | Buffer can take the codeword |
| in_data | input | CW | Codeword, raster order |
| out_valid | output | 1 | Window valid |
| out_ready | input | 1 | Downstream takes the window |
| win_data | output | 9*CW | Nine codewords of the window, packed as in R1 |
| win_row_odd | output | 1 | Parity of the strip index |
| win_col_odd | output | 1 | Parity of the group index within the strip |
| win_sof | output | 1 | First group of the frame |
| win_eof | output | 1 | Last group of the frame |

## Verification
The bench builds the block with 8-bit codewords and maxima of 16 by 16. This keeps each row store at eight entries, so a full-width frame is cheap to run. Frame sizes run from the smallest legal 2x2 up to 16x16. At 2x2, both the right-edge and the bottom-edge replication apply to the single window, and the start and end markers coincide. A 4x6 frame with the output held stalled shows the exact point at which the input is refused. Random gaps on both handshakes reach the hold behaviour and back-to-back frames.

// File: rtl/sldwin_pkg.sv
package sldwin_pkg;
  localparam int NROW = 3;
  localparam int NCOL = 3;
  localparam int NSLOT = NROW * NCOL;

  typedef enum logic [2:0] {
    RD_WAIT,
    RD_PRIME,
    RD_ISSUE,
    RD_LOAD,
    RD_SHOW
  } rd_state_t;

  // Row bank index advanced by k, modulo the three row stores.
  function automatic logic [1:0] bank_step(input logic [1:0] b, input logic [1:0] k);
    logic [2:0] t;
    t = {1'b0, b} + {1'b0, k};
    return (t >= 3'd3) ? 2'(t - 3'd3) : t[1:0];
  endfunction

  // Index of a window slot inside the packed window.
  function automatic int slot_of(input int r, input int k);
    return r * NCOL + k;
  endfunction
endpackage

// File: rtl/sldwin_rowmem.sv
module sldwin_rowmem #(
  parameter int DW = 8,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sldwin_ingest.sv
module sldwin_ingest #(
  parameter int CW = 8,
  parameter int MAX_W = 64,
  parameter int MAX_H = 64,
  localparam int WW = $clog2(MAX_W + 1),
  localparam int HW = $clog2(MAX_H + 1),
  localparam int AW = (MAX_W > 2) ? $clog2(MAX_W / 2) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [CW-1:0] in_data,
  input  logic [WW-1:0] frame_w,
  input  logic [HW-1:0] frame_h,
  input  logic [HW-1:0] top_row,
  input  logic          restart,
  output logic          in_ready,
  output logic [HW-1:0] wr_row,
  output logic          wr_fire,
  output logic [1:0]    wr_bank,
  output logic          wr_par,
  output logic [AW-1:0] wr_addr,
  output logic [CW-1:0] wr_data
);
  import sldwin_pkg::*;

  logic [WW-1:0] wcol;
  logic [HW-1:0] wrow;
  logic [1:0]    wbank;
  logic [HW:0]   row_limit;
  logic          row_end;

  // Highest row that may be written while the strip at top_row is open.
  assign row_limit = {1'b0, top_row} + (HW + 1)'(2);
  assign in_ready  = (wrow < frame_h) && ({1'b0, wrow} <= row_limit);
  assign wr_fire   = in_valid && in_ready;
  assign row_end   = (wcol == WW'(frame_w - 1'b1));

  assign wr_row  = wrow;
  assign wr_bank = wbank;
  assign wr_par  = wcol[0];
  assign wr_addr = wcol[AW:1];
  assign wr_data = in_data;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      wcol  <= '0;
      wrow  <= '0;
      wbank <= 2'd0;
    end else if (wr_fire) begin
      if (row_end) begin
        wcol  <= '0;
        wrow  <= wrow + 1'b1;
        wbank <= bank_step(wbank, 2'd1);
      end else begin
        wcol <= wcol + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sldwin_seq.sv
module sldwin_seq #(
  parameter int CW = 8,
  parameter int MAX_W = 64,
  parameter int MAX_H = 64,
  localparam int WW = $clog2(MAX_W + 1),
  localparam int HW = $clog2(MAX_H + 1),
  localparam int AW = (MAX_W > 2) ? $clog2(MAX_W / 2) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [WW-1:0]        frame_w,
  input  logic [HW-1:0]        frame_h,
  input  logic [HW-1:0]        wr_row,
  input  logic [2:0][CW-1:0]   rd_even,
  input  logic [2:0][CW-1:0]   rd_odd,
  output logic [AW-1:0]        raddr_even,
  output logic [AW-1:0]        raddr_odd,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic [8:0][CW-1:0]   win,
  output logic                 row_odd,
  output logic                 col_odd,
  output logic                 sof,
  output logic                 eof,
  output logic [HW-1:0]        top_row,
  output logic                 restart
);
  import sldwin_pkg::*;

  rd_state_t             st;
  logic [HW-1:0]         top_q;
  logic [WW-1:0]         grp;
  logic [1:0]            tb;
  logic [2:0][CW-1:0]    rcol;
  logic [8:0][CW-1:0]    win_q;
  logic [2:0][1:0]       sel_bank;
  logic [2:0][CW-1:0]    even_row;
  logic [2:0][CW-1:0]    odd_row;
  logic                  last_strip;
  logic                  last_grp;
  logic                  rows_ok;
  logic                  take;

  assign last_strip = (({1'b0, top_q} + (HW + 1)'(2)) == {1'b0, frame_h});
  assign last_grp   = (({1'b0, grp} + (WW + 1)'(1)) == {1'b0, frame_w >> 1});
  assign rows_ok    = last_strip ? (wr_row == frame_h)
                                 : ({1'b0, wr_row} > ({1'b0, top_q} + (HW + 1)'(2)));

  // Window row r reads bank tb+r; on the last strip the bottom row repeats the middle one.
  always_comb begin
    for (int r = 0; r < NROW; r++) begin
      if (r == 2 && last_strip) sel_bank[r] = bank_step(tb, 2'd1);
      else                      sel_bank[r] = bank_step(tb, 2'(r));
      even_row[r] = rd_even[sel_bank[r]];
      odd_row[r]  = rd_odd[sel_bank[r]];
    end
  end

  assign raddr_odd  = grp[AW-1:0];
  assign raddr_even = (st == RD_ISSUE) ? AW'(grp + 1'b1) : '0;

  assign take      = (st == RD_SHOW) && out_ready;
  assign out_valid = (st == RD_SHOW);
  assign win       = win_q;
  assign row_odd   = top_q[1];
  assign col_odd   = grp[0];
  assign sof       = out_valid && (top_q == '0) && (grp == '0);
  assign eof       = out_valid && last_strip && last_grp;
  assign top_row   = top_q;
  assign restart   = take && last_strip && last_grp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= RD_WAIT;
      top_q <= '0;
      grp   <= '0;
      tb    <= 2'd0;
      rcol  <= '0;
      win_q <= '0;
    end else begin
      case (st)
        RD_WAIT:  if (rows_ok) st <= RD_PRIME;
        RD_PRIME: begin
          for (int r = 0; r < NROW; r++) rcol[r] <= even_row[r];
          st <= RD_ISSUE;
        end
        RD_ISSUE: st <= RD_LOAD;
        RD_LOAD: begin
          for (int r = 0; r < NROW; r++) begin
            win_q[slot_of(r, 0)] <= rcol[r];
            win_q[slot_of(r, 1)] <= odd_row[r];
            win_q[slot_of(r, 2)] <= last_grp ? odd_row[r] : even_row[r];
            rcol[r]              <= last_grp ? odd_row[r] : even_row[r];
          end
          st <= RD_SHOW;
        end
        RD_SHOW: if (out_ready) begin
          if (!last_grp) begin
            grp <= grp + 1'b1;
            st  <= RD_ISSUE;
          end else if (last_strip) begin
            grp   <= '0;
            top_q <= '0;
            tb    <= 2'd0;
            st    <= RD_WAIT;
          end else begin
            grp   <= '0;
            top_q <= top_q + HW'(2);
            tb    <= bank_step(tb, 2'd2);
            st    <= RD_WAIT;
          end
        end
        default: st <= RD_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/sldwin_top.sv
module sldwin_top #(
  parameter int CW = 8,
  parameter int MAX_W = 64,
  parameter int MAX_H = 64,
  localparam int WW = $clog2(MAX_W + 1),
  localparam int HW = $clog2(MAX_H + 1),
  localparam int AW = (MAX_W > 2) ? $clog2(MAX_W / 2) : 1,
  localparam int DEPTH = MAX_W / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [WW-1:0]   frame_w,
  input  logic [HW-1:0]   frame_h,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [CW-1:0]   in_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [9*CW-1:0] win_data,
  output logic            win_row_odd,
  output logic            win_col_odd,
  output logic            win_sof,
  output logic            win_eof
);
  logic [HW-1:0]       wr_row;
  logic [HW-1:0]       top_row;
  logic                restart;
  logic                wr_fire;
  logic [1:0]          wr_bank;
  logic                wr_par;
  logic [AW-1:0]       wr_addr;
  logic [CW-1:0]       wr_data;
  logic [AW-1:0]       raddr_even;
  logic [AW-1:0]       raddr_odd;
  logic [2:0][CW-1:0]  rd_even;
  logic [2:0][CW-1:0]  rd_odd;
  logic [8:0][CW-1:0]  win;

  sldwin_ingest #(.CW(CW), .MAX_W(MAX_W), .MAX_H(MAX_H)) u_ingest (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .frame_w(frame_w), .frame_h(frame_h), .top_row(top_row), .restart(restart),
    .in_ready(in_ready), .wr_row(wr_row), .wr_fire(wr_fire), .wr_bank(wr_bank),
    .wr_par(wr_par), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // One store per row bank and column parity: the odd and even columns of a step are read together.
  for (genvar b = 0; b < 3; b++) begin : g_bank
    for (genvar p = 0; p < 2; p++) begin : g_par
      logic [CW-1:0] q;
      sldwin_rowmem #(.DW(CW), .DEPTH(DEPTH)) u_mem (
        .clk(clk),
        .we(wr_fire && (wr_bank == 2'(b)) && (wr_par == 1'(p))),
        .waddr(wr_addr), .wdata(wr_data),
        .raddr((p == 1) ? raddr_odd : raddr_even),
        .rdata(q)
      );
      if (p == 1) begin : g_o
        assign rd_odd[b] = q;
      end else begin : g_e
        assign rd_even[b] = q;
      end
    end
  end

  sldwin_seq #(.CW(CW), .MAX_W(MAX_W), .MAX_H(MAX_H)) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_w(frame_w), .frame_h(frame_h), .wr_row(wr_row),
    .rd_even(rd_even), .rd_odd(rd_odd), .raddr_even(raddr_even), .raddr_odd(raddr_odd),
    .out_ready(out_ready), .out_valid(out_valid), .win(win), .row_odd(win_row_odd),
    .col_odd(win_col_odd), .sof(win_sof), .eof(win_eof), .top_row(top_row),
    .restart(restart)
  );

  assign win_data = win;
endmodule

// File: rtl/sldwin_chk.sv
module sldwin_chk #(
  parameter int CW = 8,
  parameter int HW = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [9*CW-1:0] win_data,
  input logic            win_sof,
  input logic            win_eof,
  input logic [HW-1:0]   frame_h,
  input logic [HW-1:0]   wr_row,
  input logic [HW-1:0]   top_row,
  input logic            restart
);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(win_data) && $stable(win_sof) && $stable(win_eof)));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> ((wr_row < frame_h) && ({1'b0, wr_row} <= {1'b0, top_row} + 2)));

  p_full_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_row == frame_h) |-> !in_ready);

  p_rows_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((wr_row == frame_h) || ({1'b0, wr_row} > {1'b0, top_row} + 2)));

  p_sof_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
    win_sof |-> (top_row == '0));

  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && win_eof) |=> ((wr_row == '0) && (top_row == '0) && !out_valid));
endmodule

bind sldwin_top sldwin_chk #(.CW(CW), .HW(HW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .win_data(win_data),
  .win_sof(win_sof), .win_eof(win_eof), .frame_h(frame_h), .wr_row(wr_row),
  .top_row(top_row), .restart(restart)
);

// File: tb/tb_sldwin_top.sv
module tb_sldwin_top;
  localparam int CW = 8;
  localparam int MAX_W = 16;
  localparam int MAX_H = 16;
  localparam int WW = $clog2(MAX_W + 1);
  localparam int HW = $clog2(MAX_H + 1);
  localparam int EW = 9 * CW + 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_n;
  logic [WW-1:0]   frame_w;
  logic [HW-1:0]   frame_h;
  logic            in_valid;
  logic            in_ready;
  logic [CW-1:0]   in_data;
  logic            out_valid;
  logic            out_ready;
  logic [9*CW-1:0] win_data;
  logic            win_row_odd, win_col_odd, win_sof, win_eof;

  sldwin_top #(.CW(CW), .MAX_W(MAX_W), .MAX_H(MAX_H)) dut (
    .clk(clk), .rst_n(rst_n), .frame_w(frame_w), .frame_h(frame_h),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .win_data(win_data),
    .win_row_odd(win_row_odd), .win_col_odd(win_col_odd),
    .win_sof(win_sof), .win_eof(win_eof)
  );

  int n_chk = 0;
  int n_fail = 0;
  int accepted = 0;
  int rdy_mode = 0;
  bit gaps = 0;
  bit done = 0;
  bit send_done = 0;
  logic [EW-1:0] expq[$];
  logic [9*CW-1:0] prev_win;
  bit prev_stall = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] pix(input int f, input int r, input int c);
    return CW'((f * 53 + r * 17 + c * 3 + 7) % 256);
  endfunction

  // Expected window: slot (r,k) at bits (3r+k)*CW, clipped at the right and bottom edges.
  function automatic logic [EW-1:0] exp_grp(input int f, input int w, input int h, input int s, input int g);
    logic [9*CW-1:0] wv;
    int rr, cc;
    bit ls, lg;
    wv = '0;
    for (int r = 0; r < 3; r++)
      for (int k = 0; k < 3; k++) begin
        rr = (2 * s + r > h - 1) ? h - 1 : 2 * s + r;
        cc = (2 * g + k > w - 1) ? w - 1 : 2 * g + k;
        wv[(3 * r + k) * CW +: CW] = pix(f, rr, cc);
      end
    ls = (s == h / 2 - 1);
    lg = (g == w / 2 - 1);
    return {wv, (s == 0 && g == 0), (ls && lg), s[0], g[0], lg, ls};
  endfunction

  task automatic push_frame(input int f, input int w, input int h);
    for (int s = 0; s < h / 2; s++)
      for (int g = 0; g < w / 2; g++) expq.push_back(exp_grp(f, w, h, s, g));
  endtask

  task automatic send_words(input int f, input int w, input int from, input int upto);
    bit got;
    for (int i = from; i < upto; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = pix(f, i / w, i % w);
      do begin
        got = in_ready;
        @(negedge clk);
      end while (!got);
      accepted++;
    end
    in_valid = 1'b0;
  endtask

  // Scoreboard monitor: decides out_ready, then compares the window taken at the next edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [EW-1:0] e;
      bit rdy;
      string tag;
      rdy = (rdy_mode == 2) ? 1'b1 : (rdy_mode == 1) ? ($urandom % 3 != 0) : 1'b0;
      out_ready = rdy;
      if (prev_stall)  // R7: a stalled window stays put
        chk(out_valid && win_data == prev_win, "R7 hold", {out_valid, win_data}, {1'b1, prev_win});
      if (out_valid && rdy) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R2 extra window", win_data, 0);
        end else begin
          e = expq.pop_front();
          tag = e[1] ? "R3 right edge" : e[0] ? "R4 bottom edge" : "R1 window";
          chk(win_data == e[EW-1:6], tag, win_data, e[EW-1:6]);
          chk({win_sof, win_eof} == e[5:4], "R8 markers", {win_sof, win_eof}, e[5:4]);
          chk({win_row_odd, win_col_odd} == e[3:2], "R9 parity", {win_row_odd, win_col_odd}, e[3:2]);
        end
      end
      prev_stall = out_valid && !rdy;
      prev_win   = win_data;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired, run hung");
    finish_run();
  end

  task automatic drain_and_check(input string lbl);
    while (!send_done || expq.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(!out_valid && expq.size() == 0, "R2 no trailing window", out_valid, 0);
    chk(in_ready == 1'b1, "R10 ready for next frame", in_ready, 1);
    $display("frame %s drained", lbl);
  endtask

  task automatic run_frame(input int f, input int w, input int h, input int mode, input bit gp);
    frame_w = WW'(w);
    frame_h = HW'(h);
    rdy_mode = mode;
    gaps = gp;
    push_frame(f, w, h);
    send_done = 0;
    fork begin
      send_words(f, w, 0, w * h);
      send_done = 1;
    end join_none
    drain_and_check($sformatf("%0d", f));
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    out_ready = 1'b0;
    frame_w = WW'(4);
    frame_h = HW'(6);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R11 reset out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R11 reset in_ready", in_ready, 1);

    // Frame 1: 4x6, output stalled; check start point and input refusal.
    rdy_mode = 0;
    push_frame(1, 4, 6);
    send_words(1, 4, 0, 11);
    repeat (10) @(negedge clk);
    chk(out_valid == 1'b0, "R5 no window before third row", out_valid, 0);
    send_words(1, 4, 11, 12);
    repeat (8) @(negedge clk);
    chk(out_valid == 1'b1, "R5 window after third row", out_valid, 1);
    send_done = 0;
    fork begin
      send_words(1, 4, 12, 24);
      send_done = 1;
    end join_none
    repeat (40) @(negedge clk);
    chk(accepted == 12, "R6 accepted while stalled", accepted, 12);
    chk(in_ready == 1'b0, "R6 ready low while stalled", in_ready, 0);
    rdy_mode = 1;
    drain_and_check("1");

    // Smallest frame: both edges replicated, sof and eof together; R10 restart path.
    run_frame(2, 2, 2, 1, 1);
    run_frame(3, 8, 6, 1, 1);
    run_frame(4, 16, 16, 2, 0);
    run_frame(5, 6, 4, 1, 0);
    finish_run();
  end
endmodule